// File: doc/BRIEF.md
# Approximate Vector Magnitude Unit

This unit estimates the length of a 2-D vector or a complex sample without squares or square roots. It accepts a signed pair of components with a valid strobe. It forms the absolute value of each component, sorts the two into a larger and a smaller value, and adds them with a pair of fixed weights.

A per-sample mode bit picks one of two weight sets. The coarse set adds one third of the smaller value to the larger one. Its error runs from about -5.7% at 45 degrees to about +5.4% near 18.4 degrees. The fine set applies two 16-bit fractional weights, 62943/65536 and 26072/65536, and keeps the error within about +/-3.96%. In that set, the worst low error falls at 0 and 45 degrees and the worst high error at 22.5 degrees.

The unit is a fixed two-stage pipeline. A new sample can enter on every cycle, and the valid flag travels with the data.

Top module: `vec_mag_est`

## Requirements
- R1: Each component is a 16-bit two's complement value. Its absolute value is taken as unsigned, so -32768 counts as 32768.
- R2: When in_mode is 0 (coarse), out_mag equals big + floor(small/3). Here big and small are the larger and the smaller of the two absolute values.
- R3: When in_mode is 1 (fine), out_mag equals floor((62943*big + 26072*small) / 65536).
- R4: The result is the same whichever component carries the larger magnitude and whatever the signs of the components.
- R5: Each cycle with in_valid high gives exactly one cycle with out_valid high, two clock edges later. Back-to-back samples give back-to-back results in input order.
- R6: out_mag keeps its last value while out_valid is low. Samples presented with in_valid low do not change any later output.
- R7: out_mag never exceeds 44507, the fine result for two components of -32768. The top bit of the 18-bit output therefore stays 0.
- R8: While rst_n is low, out_valid and out_mag are 0.
- R9: The mode is taken with each sample, so the weight set can change from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_x | input | 16 | Signed first component |
| in_y | input | 16 | Signed second component |
| in_mode | input | 1 | Weight set: 0 coarse, 1 fine |
| out_valid | output | 1 | Result strobe |
| out_mag | output | 18 | Unsigned magnitude estimate |

## Verification
A wrong absolute value or a swapped big/small pair makes out_mag differ from the model exactly two edges after the affected sample. Corner values such as -32768 and equal components make these errors visible. A weight or reciprocal error shows the same way, often only as an off-by-one at large inputs. A slipped valid stage makes a result appear one cycle early or late, or go missing. A result that changes while out_valid is low shows up on the next idle cycle.

// File: rtl/vmag_pkg.sv
package vmag_pkg;

  typedef enum logic {
    MODE_COARSE = 1'b0,
    MODE_FINE   = 1'b1
  } vmag_mode_e;

  localparam int FINE_SHIFT = 16;
  localparam int FINE_K_BIG = 62943;
  localparam int FINE_K_SML = 26072;

  // Rounded-up reciprocal of three at 2^sh scale; exact floor for m < 2^sh.
  function automatic int recip3(input int sh);
    return ((1 << sh) + 2) / 3;
  endfunction

endpackage

// File: rtl/vmag_abs.sv
module vmag_abs #(
  parameter int W = 16
) (
  input  logic [W-1:0] comp_i,
  output logic [W-1:0] mag_o
);
  // Unsigned result, so the most negative input maps to 2^(W-1).
  always_comb begin
    if (comp_i[W-1]) mag_o = ~comp_i + W'(1);
    else             mag_o = comp_i;
  end
endmodule

// File: rtl/vmag_order.sv
module vmag_order #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] big_o,
  output logic [W-1:0] small_o
);
  logic a_ge_b;

  always_comb begin
    a_ge_b  = (a_i >= b_i);
    big_o   = a_ge_b ? a_i : b_i;
    small_o = a_ge_b ? b_i : a_i;
  end
endmodule

// File: rtl/vmag_weight.sv
module vmag_weight
  import vmag_pkg::*;
#(
  parameter int W  = 16,
  parameter int OW = W + 2
) (
  input  logic [W-1:0]  big_i,
  input  logic [W-1:0]  small_i,
  input  vmag_mode_e    mode_i,
  output logic [OW-1:0] mag_o
);
  localparam int SH3 = W + 1;
  localparam int PW3 = W + SH3;
  localparam int PWF = W + FINE_SHIFT + 1;
  localparam logic [PW3-1:0] K3 = PW3'(recip3(SH3));
  localparam logic [PWF-1:0] KB = PWF'(FINE_K_BIG);
  localparam logic [PWF-1:0] KS = PWF'(FINE_K_SML);

  logic [PW3-1:0] third_prod;
  logic [W-1:0]   third;
  logic [OW-1:0]  coarse_sum;
  logic [PWF-1:0] fine_acc;
  logic [OW-1:0]  fine_sum;

  always_comb begin
    third_prod = PW3'(small_i) * K3;
    third      = third_prod[PW3-1:SH3];
    coarse_sum = OW'(big_i) + OW'(third);
    fine_acc   = PWF'(big_i) * KB + PWF'(small_i) * KS;
    fine_sum   = OW'(fine_acc[PWF-1:FINE_SHIFT]);
    mag_o      = (mode_i == MODE_FINE) ? fine_sum : coarse_sum;
  end
endmodule

// File: rtl/vec_mag_est.sv
module vec_mag_est
  import vmag_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int OUT_W = IN_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_x,
  input  logic signed [IN_W-1:0]  in_y,
  input  logic                    in_mode,
  output logic                    out_valid,
  output logic [OUT_W-1:0]        out_mag
);
  localparam int NCOMP = 2;

  logic [IN_W-1:0] comp_raw [NCOMP];
  logic [IN_W-1:0] comp_abs [NCOMP];
  logic [IN_W-1:0] big_c, small_c;

  // Stage 1 state
  logic [IN_W-1:0] s1_big_q, s1_big_d;
  logic [IN_W-1:0] s1_sml_q, s1_sml_d;
  vmag_mode_e      s1_mode_q, s1_mode_d;
  logic            s1_vld_q, s1_vld_d;

  // Stage 2 state
  logic [OUT_W-1:0] s2_mag_q, s2_mag_d;
  logic             s2_vld_q, s2_vld_d;
  logic [OUT_W-1:0] weighted;

  always_comb begin
    comp_raw[0] = in_x;
    comp_raw[1] = in_y;
  end

  for (genvar g = 0; g < NCOMP; g++) begin : g_abs
    vmag_abs #(.W(IN_W)) u_abs (
      .comp_i (comp_raw[g]),
      .mag_o  (comp_abs[g])
    );
  end

  vmag_order #(.W(IN_W)) u_order (
    .a_i     (comp_abs[0]),
    .b_i     (comp_abs[1]),
    .big_o   (big_c),
    .small_o (small_c)
  );

  // Stage 1 next state: data loads only with a valid sample.
  always_comb begin
    s1_vld_d  = in_valid;
    s1_big_d  = s1_big_q;
    s1_sml_d  = s1_sml_q;
    s1_mode_d = s1_mode_q;
    if (in_valid) begin
      s1_big_d  = big_c;
      s1_sml_d  = small_c;
      s1_mode_d = vmag_mode_e'(in_mode);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q  <= 1'b0;
      s1_big_q  <= '0;
      s1_sml_q  <= '0;
      s1_mode_q <= MODE_COARSE;
    end else begin
      s1_vld_q  <= s1_vld_d;
      s1_big_q  <= s1_big_d;
      s1_sml_q  <= s1_sml_d;
      s1_mode_q <= s1_mode_d;
    end
  end

  vmag_weight #(.W(IN_W), .OW(OUT_W)) u_weight (
    .big_i   (s1_big_q),
    .small_i (s1_sml_q),
    .mode_i  (s1_mode_q),
    .mag_o   (weighted)
  );

  // Stage 2 next state: result register holds while idle.
  always_comb begin
    s2_vld_d = s1_vld_q;
    s2_mag_d = s1_vld_q ? weighted : s2_mag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_vld_q <= 1'b0;
      s2_mag_q <= '0;
    end else begin
      s2_vld_q <= s2_vld_d;
      s2_mag_q <= s2_mag_d;
    end
  end

  assign out_valid = s2_vld_q;
  assign out_mag   = s2_mag_q;

endmodule

// File: rtl/vmag_chk.sv
module vmag_chk #(
  parameter int IN_W  = 16,
  parameter int OUT_W = IN_W + 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic signed [IN_W-1:0] in_x,
  input logic signed [IN_W-1:0] in_y,
  input logic                   in_mode,
  input logic                   out_valid,
  input logic [OUT_W-1:0]       out_mag
);
  localparam longint HALF = longint'(1) << (IN_W - 1);
  localparam longint CAP  = (HALF * 89015) >> 16;

  longint ax, ay, big_now;

  always_comb begin
    ax      = (in_x < 0) ? -longint'(in_x) : longint'(in_x);
    ay      = (in_y < 0) ? -longint'(in_y) : longint'(in_y);
    big_now = (ax > ay) ? ax : ay;
  end

  AST_VALID_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid); // R5

  AST_VALID_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_mag)); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (longint'(out_mag) <= CAP)); // R7

  AST_COARSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(in_mode, 2)) |->
      (longint'(out_mag) >= $past(big_now, 2) &&
       longint'(out_mag) <= $past(big_now, 2) + $past(big_now, 2) / 3)); // R2

  AST_FINE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_mode, 2)) |->
      (longint'(out_mag) >= (($past(big_now, 2) * 62943) >> 16))); // R3

endmodule

bind vec_mag_est vmag_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_vmag_chk (.*);

// File: tb/tb_vec_mag_est.sv
module tb_vec_mag_est;
  localparam int IN_W  = 16;
  localparam int OUT_W = 18;

  logic                   clk;
  logic                   rst_n;
  logic                   in_valid;
  logic signed [IN_W-1:0] in_x;
  logic signed [IN_W-1:0] in_y;
  logic                   in_mode;
  logic                   out_valid;
  logic [OUT_W-1:0]       out_mag;

  vec_mag_est #(.IN_W(IN_W), .OUT_W(OUT_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x),
    .in_y(in_y), .in_mode(in_mode), .out_valid(out_valid), .out_mag(out_mag)
  );

  int checks = 0;
  int fails  = 0;
  logic [OUT_W-1:0] exp_q [$];
  string            tag_q [$];
  logic [OUT_W-1:0] last_mag = '0;
  int unsigned      lcg = 32'h1234_5678;
  bit               done = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // Model built from R1..R3
  function automatic logic [OUT_W-1:0] model(input int x, input int y, input bit m);
    longint ax, ay, big, sml;
    ax  = (x < 0) ? -longint'(x) : longint'(x);
    ay  = (y < 0) ? -longint'(y) : longint'(y);
    big = (ax > ay) ? ax : ay;
    sml = (ax > ay) ? ay : ax;
    if (!m) return OUT_W'(big + sml / 3);
    return OUT_W'((big * 62943 + sml * 26072) >> 16);
  endfunction

  task automatic send(input int x, input int y, input bit m, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_x     = IN_W'(x);
    in_y     = IN_W'(y);
    in_mode  = m;
    exp_q.push_back(model(x, y, m));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lcg      = lcg * 1103515245 + 12345;
      in_valid = 1'b0;
      in_x     = IN_W'(lcg[31:16]);
      in_y     = IN_W'(lcg[15:0]);
      in_mode  = lcg[3];
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R5 unexpected result", longint'(out_mag), -1);
        end else begin
          logic [OUT_W-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_mag == e, t, longint'(out_mag), longint'(e));
          check(out_mag <= 44507 && !out_mag[OUT_W-1], "R7 range", longint'(out_mag), 44507);
        end
        last_mag = out_mag;
      end else begin
        check(out_mag == last_mag, "R6 hold while idle", longint'(out_mag), longint'(last_mag));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_x     = '0;
    in_y     = '0;
    in_mode  = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R8 reset valid", longint'(out_valid), 0);
    check(out_mag == '0, "R8 reset mag", longint'(out_mag), 0);
    rst_n = 1'b1;
    idle(3);

    // R1 most negative value
    send(-32768, 0, 1'b0, "R1 abs -32768 coarse");
    send(0, -32768, 1'b1, "R1 abs -32768 fine");
    send(-32768, -32768, 1'b0, "R1 R7 both min coarse");
    send(-32768, -32768, 1'b1, "R7 both min fine peak");
    send(32767, 32767, 1'b1, "R3 45deg fine");
    send(0, 0, 1'b0, "R2 zero");
    // R2 coarse, remainders of three
    send(30, 3, 1'b0, "R2 small rem0");
    send(30, 4, 1'b0, "R2 small rem1");
    send(30, 5, 1'b0, "R2 small rem2");
    send(32767, 32766, 1'b0, "R2 large floor");
    // R4 symmetry
    send(1000, -300, 1'b1, "R4 base");
    send(-300, 1000, 1'b1, "R4 swapped");
    send(-1000, 300, 1'b1, "R4 signs");
    send(300, -1000, 1'b0, "R4 coarse swapped");
    // R9 alternating mode back to back
    for (int i = 0; i < 8; i++) send(12345, -6789, i[0], "R9 mode per sample");
    idle(4);
    // R6 gap then resume
    send(-7, 7, 1'b0, "R6 after gap");
    idle(2);
    // R3/R5 random back-to-back stream
    for (int i = 0; i < 60; i++) begin
      lcg = lcg * 1103515245 + 12345;
      send(int'($signed(lcg[31:16])), int'($signed(lcg[15:0])), lcg[7], "R3 R5 stream");
    end
    idle(6);
    check(exp_q.size() == 0, "R5 all results seen", longint'(exp_q.size()), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule